// File: doc/BRIEF.md
# SDRAM Mode Register Programming Unit

This block writes the SDRAM mode register when asked. A requester presents a CAS latency code, a burst type bit and a burst length code, then pulses a request for one cycle. The unit checks the codes, waits until the bank tracker reports that every bank is precharged, and then drives one mode-register-set cycle: RAS#, CAS# and WE# all low, with the settings encoded on the address bus. One completion cycle with no command follows, and then the unit pulses `done_o`.

The mode register holds undefined contents after power-up. A dedicated power-up trigger starts the same programming sequence and first clears the `valid_o` flag. Until a programming pass completes, `valid_o` stays low, and other logic must not issue reads or writes. The settings from the last successful pass stay latched on `cur_*` outputs for the read and write paths to use. A request that carries an unsupported code raises a one-cycle error pulse and drives nothing onto the bus.

Top module: `sdram_mode_prog`

## Requirements
- R1: After reset, the command pins are at NOP (`ras_n_o`, `cas_n_o` and `we_n_o` all 1), `addr_o` is 0, and `busy_o`, `done_o`, `err_o` and `valid_o` are all 0.
- R2: The programming command is RAS#=CAS#=WE#=0 for exactly one cycle. In that cycle `addr_o[2:0]` carries the burst length code, `addr_o[3]` carries the burst type (0 sequential, 1 interleaved), `addr_o[6:4]` carries the CAS latency code, and every higher address bit is 0.
- R3: When `banks_idle_i` is 1, the command is on the pins after the second rising edge following the request (sampled at edge E0, driven from E1 to E2).
- R4: A command is issued only on an edge at which `banks_idle_i` is 1. While it is 0, an accepted request stays pending with NOP on the pins.
- R5: The cycle after the command is a NOP completion cycle. `done_o` is high for exactly one cycle, starting at the second edge after the command edge.
- R6: The accepted CAS codes are 010 (2) and 011 (3). The accepted burst length codes are 000 (1), 001 (2), 010 (4), 011 (8) and 111 (full page). Any other code gives a one-cycle `err_o` pulse starting at the edge after the request, with no command and `busy_o` staying low.
- R7: `cur_cas_o`, `cur_btype_o` and `cur_blen_o` take the programmed settings at the same edge as `done_o` rises. They are not changed by a rejected request.
- R8: `valid_o` rises together with the first `done_o` and stays high. An accepted `pwrup_i` clears it at the edge that accepts the trigger, and programming then proceeds as for a request.
- R9: A `req_i` or `pwrup_i` pulse that arrives while `busy_o` is high is ignored.
- R10: `busy_o` is high from the edge after an accepted request until the edge at which `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Programming request pulse |
| pwrup_i | input | 1 | Power-up programming trigger, also clears `valid_o` |
| cas_code_i | input | 3 | Requested CAS latency code |
| btype_i | input | 1 | Requested burst type |
| blen_code_i | input | 3 | Requested burst length code |
| banks_idle_i | input | 1 | High when all banks are idle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus carrying the register value |
| busy_o | output | 1 | Programming in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for an unsupported code |
| valid_o | output | 1 | Mode register holds known contents |
| cur_cas_o | output | 3 | Latched CAS latency code |
| cur_btype_o | output | 1 | Latched burst type |
| cur_blen_o | output | 3 | Latched burst length code |

## Verification
Each result has a fixed time after its stimulus. `err_o` and `busy_o` are due one edge after the request. The command is due one edge after the first edge that sees `banks_idle_i` high. `done_o`, `valid_o` and the latched settings are due two edges after the command. The bench drives inputs on the falling edge and counts rising edges itself, so it samples each result at the falling edge that follows the edge where that result is due. In the cycles before and after each result, it also checks that the command pins are at NOP and that `done_o` is low.

// File: rtl/sdram_mr_pkg.sv
// Package: shared field layout, state type and code checks for the
// mode register programming unit. Assumes the standard low-order field
// layout: burst length, then burst type, then CAS latency.
package sdram_mr_pkg;

    localparam int BL_LSB  = 0;
    localparam int BT_BIT  = 3;
    localparam int CL_LSB  = 4;
    localparam int FIELD_W = 7;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_WAIT = 2'd1,
        MS_CMD  = 2'd2,
        MS_GAP  = 2'd3
    } mr_state_t;

    // True for the CAS latency codes this unit supports.
    function automatic logic cas_supported(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b011);
    endfunction

    // True for the burst length codes this unit supports.
    function automatic logic blen_supported(input logic [2:0] code);
        return (code == 3'b000) || (code == 3'b001) || (code == 3'b010) ||
               (code == 3'b011) || (code == 3'b111);
    endfunction

endpackage

// File: rtl/mr_cfg_check.sv
// mr_cfg_check: combinational check and packing of the requested settings.
// Assumes the inputs are stable in the cycle that carries the request.
module mr_cfg_check
    import sdram_mr_pkg::*;
(
    input  logic [2:0]         cas_code_i,
    input  logic               btype_i,
    input  logic [2:0]         blen_code_i,
    output logic               ok_o,
    output logic [FIELD_W-1:0] field_o
);

    // Accept only supported codes and pack them into register layout.
    always_comb begin
        ok_o    = cas_supported(cas_code_i) && blen_supported(blen_code_i);
        field_o = '0;
        field_o[BL_LSB +: 3] = blen_code_i;
        field_o[BT_BIT]      = btype_i;
        field_o[CL_LSB +: 3] = cas_code_i;
    end

endmodule

// File: rtl/mr_seq_fsm.sv
// mr_seq_fsm: sequences one programming pass: hold the settings, wait for
// all banks idle, issue one command cycle, spend one completion cycle,
// then pulse done. Assumes req/pwrup are single-cycle pulses.
module mr_seq_fsm
    import sdram_mr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               cfg_ok_i,
    input  logic [FIELD_W-1:0] cfg_field_i,
    input  logic               banks_idle_i,
    output logic               mrs_o,
    output logic [FIELD_W-1:0] field_o,
    output logic               accept_o,
    output logic               finish_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);

    mr_state_t          state_q;
    mr_state_t          state_d;
    logic [FIELD_W-1:0] field_q;
    logic               mrs_q;
    logic               done_q;
    logic               err_q;

    // Decode accept and finish conditions for the other blocks.
    always_comb begin
        accept_o = (state_q == MS_IDLE) && start_i && cfg_ok_i;
        finish_o = (state_q == MS_GAP);
    end

    // Next-state logic for one programming pass.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: if (accept_o)     state_d = MS_WAIT;
            MS_WAIT: if (banks_idle_i) state_d = MS_CMD;
            MS_CMD:                    state_d = MS_GAP;
            MS_GAP:                    state_d = MS_IDLE;
            default:                   state_d = MS_IDLE;
        endcase
    end

    // State, held settings and registered pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            field_q <= '0;
            mrs_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_o) field_q <= cfg_field_i;
            mrs_q   <= (state_q == MS_WAIT) && banks_idle_i;
            done_q  <= finish_o;
            err_q   <= (state_q == MS_IDLE) && start_i && !cfg_ok_i;
        end
    end

    assign mrs_o   = mrs_q;
    assign field_o = field_q;
    assign busy_o  = (state_q != MS_IDLE);
    assign done_o  = done_q;
    assign err_o   = err_q;

endmodule

// File: rtl/mr_shadow.sv
// mr_shadow: keeps a copy of the last programmed settings and the valid
// flag. Assumes finish and power-up accept never coincide.
module mr_shadow
    import sdram_mr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               finish_i,
    input  logic               pwr_clear_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic               valid_o,
    output logic [2:0]         cas_o,
    output logic               btype_o,
    output logic [2:0]         blen_o
);

    logic [FIELD_W-1:0] shadow_q;
    logic               valid_q;

    // Latch settings on completion; power-up trigger drops validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            if (finish_i) begin
                shadow_q <= field_i;
                valid_q  <= 1'b1;
            end else if (pwr_clear_i) begin
                valid_q  <= 1'b0;
            end
        end
    end

    assign valid_o = valid_q;
    assign cas_o   = shadow_q[CL_LSB +: 3];
    assign btype_o = shadow_q[BT_BIT];
    assign blen_o  = shadow_q[BL_LSB +: 3];

endmodule

// File: rtl/sdram_mode_prog.sv
// sdram_mode_prog: top of the mode register programming unit. Drives the
// command pins and address bus, reports status, and exposes the latched
// settings. Assumes a bank tracker supplies banks_idle_i in this domain.
module sdram_mode_prog
    import sdram_mr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              pwrup_i,
    input  logic [2:0]        cas_code_i,
    input  logic              btype_i,
    input  logic [2:0]        blen_code_i,
    input  logic              banks_idle_i,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              valid_o,
    output logic [2:0]        cur_cas_o,
    output logic              cur_btype_o,
    output logic [2:0]        cur_blen_o
);

    localparam int PAD_W = ADDR_W - FIELD_W;

    logic               cfg_ok;
    logic [FIELD_W-1:0] cfg_field;
    logic [FIELD_W-1:0] held_field;
    logic               mrs;
    logic               accept;
    logic               finish;

    mr_cfg_check u_check (
        .cas_code_i  (cas_code_i),
        .btype_i     (btype_i),
        .blen_code_i (blen_code_i),
        .ok_o        (cfg_ok),
        .field_o     (cfg_field)
    );

    mr_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (req_i | pwrup_i),
        .cfg_ok_i     (cfg_ok),
        .cfg_field_i  (cfg_field),
        .banks_idle_i (banks_idle_i),
        .mrs_o        (mrs),
        .field_o      (held_field),
        .accept_o     (accept),
        .finish_o     (finish),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    mr_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .finish_i    (finish),
        .pwr_clear_i (accept & pwrup_i),
        .field_i     (held_field),
        .valid_o     (valid_o),
        .cas_o       (cur_cas_o),
        .btype_o     (cur_btype_o),
        .blen_o      (cur_blen_o)
    );

    // Drive the command pins: all strobes low only in the command cycle.
    always_comb begin
        ras_n_o = ~mrs;
        cas_n_o = ~mrs;
        we_n_o  = ~mrs;
        addr_o  = mrs ? {{PAD_W{1'b0}}, held_field} : '0;
    end

endmodule

// File: rtl/sdram_mode_prog_chk.sv
// sdram_mode_prog_chk: protocol checker bound to sdram_mode_prog.
// Observes ports only.
module sdram_mode_prog_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              banks_idle_i,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              valid_o
);

    logic mrs_seen;
    logic nop_seen;
    assign mrs_seen = !ras_n_o && !cas_n_o && !we_n_o;
    assign nop_seen = ras_n_o && cas_n_o && we_n_o;

    AST_ADDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_seen |-> (addr_o[ADDR_W-1:7] == '0)); // R2
    AST_CMD_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_seen |-> $past(banks_idle_i)); // R4
    AST_CMD_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_seen |=> nop_seen); // R5
    AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mrs_seen, 2)); // R5
    AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (nop_seen && !busy_o)); // R6
    AST_VALID_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> done_o); // R8
    AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_seen |-> busy_o); // R10

endmodule

bind sdram_mode_prog sdram_mode_prog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .banks_idle_i (banks_idle_i),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n_o),
    .we_n_o       (we_n_o),
    .addr_o       (addr_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .valid_o      (valid_o)
);

// File: tb/sdram_mode_prog_tb.sv
module sdram_mode_prog_tb;

    localparam int ADDR_W = 12;
    localparam int NVEC   = 8;
    // Fields: {cas[2:0], btype, blen[2:0], idle_delay[2:0], expect_err}
    localparam logic [10:0] VEC [NVEC] = '{
        {3'b011, 1'b0, 3'b011, 3'd0, 1'b0},
        {3'b010, 1'b1, 3'b010, 3'd2, 1'b0},
        {3'b100, 1'b0, 3'b001, 3'd0, 1'b1},
        {3'b011, 1'b1, 3'b111, 3'd0, 1'b0},
        {3'b011, 1'b0, 3'b100, 3'd0, 1'b1},
        {3'b010, 1'b0, 3'b000, 3'd5, 1'b0},
        {3'b001, 1'b1, 3'b011, 3'd1, 1'b1},
        {3'b010, 1'b0, 3'b001, 3'd1, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic              pwrup_i = 1'b0;
    logic [2:0]        cas_code_i = 3'b0;
    logic              btype_i = 1'b0;
    logic [2:0]        blen_code_i = 3'b0;
    logic              banks_idle_i = 1'b0;
    logic              ras_n_o, cas_n_o, we_n_o;
    logic [ADDR_W-1:0] addr_o;
    logic              busy_o, done_o, err_o, valid_o;
    logic [2:0]        cur_cas_o, cur_blen_o;
    logic              cur_btype_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [6:0] exp_cur = '0;
    logic       exp_valid = 1'b0;

    sdram_mode_prog #(.ADDR_W(ADDR_W)) u_dut (.*);

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Pulse a start, then follow one programming pass with cycle checks.
    task automatic run_pass(input logic [2:0] cas, input logic bt, input logic [2:0] bl,
                            input int delay, input logic exp_err, input logic pwr);
        cas_code_i = cas; btype_i = bt; blen_code_i = bl;
        req_i = !pwr; pwrup_i = pwr;
        banks_idle_i = (delay == 0);
        tick();
        req_i = 1'b0; pwrup_i = 1'b0;
        if (exp_err) begin
            chk("R6 err pulse", err_o, 1);
            chk("R6 no busy", busy_o, 0);
            chk("R6 no cmd", {ras_n_o, cas_n_o, we_n_o}, 3'b111);
            tick();
            chk("R6 err one cycle", err_o, 0);
            chk("R7 cur unchanged", {cur_cas_o, cur_btype_o, cur_blen_o}, exp_cur);
            return;
        end
        chk("R10 busy after accept", busy_o, 1);
        if (pwr) begin
            exp_valid = 1'b0;
            chk("R8 pwrup clears valid", valid_o, 0);
        end
        for (int i = 1; i < delay; i++) begin
            tick();
            chk("R4 pending nop", {ras_n_o, cas_n_o, we_n_o}, 3'b111);
        end
        banks_idle_i = 1'b1;
        tick();
        chk("R2 R3 cmd strobes", {ras_n_o, cas_n_o, we_n_o}, 3'b000);
        chk("R2 addr", addr_o, {5'b0, cas, bt, bl});
        banks_idle_i = 1'b0;
        tick();
        chk("R5 gap nop", {ras_n_o, cas_n_o, we_n_o}, 3'b111);
        chk("R5 no early done", done_o, 0);
        tick();
        exp_cur = {cas, bt, bl};
        exp_valid = 1'b1;
        chk("R5 done", done_o, 1);
        chk("R10 busy drops", busy_o, 0);
        chk("R8 valid", valid_o, 1);
        chk("R7 cur", {cur_cas_o, cur_btype_o, cur_blen_o}, exp_cur);
        tick();
        chk("R5 done one cycle", done_o, 0);
    endtask

    initial begin
        tick(); tick();
        chk("R1 strobes", {ras_n_o, cas_n_o, we_n_o}, 3'b111);
        chk("R1 addr", addr_o, 0);
        chk("R1 flags", {busy_o, done_o, err_o, valid_o}, 4'b0000);
        rst_n = 1'b1;
        tick();

        // Power-up pass first
        run_pass(3'b011, 1'b0, 3'b010, 0, 1'b0, 1'b1);

        for (int v = 0; v < NVEC; v++) begin
            run_pass(VEC[v][10:8], VEC[v][7], VEC[v][6:4], int'(VEC[v][3:1]), VEC[v][0], 1'b0);
            tick();
        end

        // R9: second request while pending is ignored
        cas_code_i = 3'b010; btype_i = 1'b1; blen_code_i = 3'b001;
        req_i = 1'b1; banks_idle_i = 1'b0;
        tick();
        cas_code_i = 3'b011; btype_i = 1'b0; blen_code_i = 3'b111;
        pwrup_i = 1'b1;
        tick();
        req_i = 1'b0; pwrup_i = 1'b0;
        chk("R9 valid kept", valid_o, 1);
        banks_idle_i = 1'b1;
        tick();
        chk("R9 addr from first", addr_o, {5'b0, 3'b010, 1'b1, 3'b001});
        banks_idle_i = 1'b0;
        tick(); tick();
        chk("R9 cur from first", {cur_cas_o, cur_btype_o, cur_blen_o}, 7'b010_1_001);
        tick();

        // R8: power-up trigger clears valid, then reprograms
        run_pass(3'b010, 1'b0, 3'b011, 3, 1'b0, 1'b1);

        // R1: reset mid-pass returns to idle state
        req_i = 1'b1; banks_idle_i = 1'b0;
        tick();
        req_i = 1'b0; rst_n = 1'b0;
        tick();
        chk("R1 reset busy", busy_o, 0);
        chk("R1 reset valid", valid_o, 0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule